// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches 32 general-purpose input pins and turns their activity into a single interrupt request for a processor. Each pin is synchronised to the system clock. Per pin, software selects level or edge detection, the active polarity for level detection, rising and falling edge qualifiers for edge detection, and whether a detected event is latched or only mirrored. The result lands in a per-pin status bit. Software clears status by writing ones.

Each control and status function is split into two 16-bit registers: one for pins 0 to 15 and one for pins 16 to 31. A pin requests service only when both its status bit and its enable bit are set. The block drives one combined interrupt line. It also reports the number of the lowest-numbered pin that is requesting service, so that a handler can go straight to the right source.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, every control register reads back zero, `irq_o` is low and `pend_valid_o` is low.
- R2: Register byte offsets are as follows. In each pair, the first offset is the low half and the second is the high half.
  - status: 0x08 / 0x0A
  - enable: 0x0C / 0x0E
  - trigger type: 0x10 / 0x12
  - level select: 0x14 / 0x16
  - hold: 0x18 / 0x1A
  - falling-edge enable: 0x20 / 0x22
  - rising-edge enable: 0x24 / 0x26

  Bit i of a low register belongs to pin i, and bit i of a high register belongs to pin 16+i. A read returns the register on `bus_rdata` one clock after it is issued. Unmapped offsets read zero.
- R3: A pin change sampled at a clock edge reaches the status bit on the third clock edge. Two edges pass through the synchroniser and one through the status register.
- R4: With trigger type 0 (level), the status bit tracks whether the pin equals its level-select bit. A level-select of 1 means active high and 0 means active low.
- R5: With trigger type 1 (edge), a 0-to-1 transition counts only if the rising enable is 1, and a 1-to-0 transition counts only if the falling enable is 1. With both enables set, either edge counts.
- R6: With the hold bit at 1, a set status bit stays set until software clears it.
- R7: A write to a status register clears every status bit whose written bit is 1 and leaves the others alone.
- R8: If an event and a clear of the same status bit land in the same cycle, the bit ends up set.
- R9: With the hold bit at 0 in edge mode, each counted edge raises the status bit for exactly one clock.
- R10: `irq_o` is high exactly when some pin has both status and enable set.
- R11: `pend_pin_o` gives the lowest requesting pin among pins 0 to 15. Only when none of those is requesting does it give the lowest requesting pin among 16 to 31, reported as its own number (16 + bit index). `pend_valid_o` marks a valid report.
- R12: Reading a status register returns the current status bits of its half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous input pins |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the clock after a read |
| irq_o | output | 1 | Combined interrupt request |
| pend_valid_o | output | 1 | A requesting pin exists |
| pend_pin_o | output | 5 | Number of the lowest requesting pin |

## Verification
On every cycle, the assertions check the following:
- The status update rules: a clear removes a bit unless an event arrives, an event always lands, and held bits persist.
- That the interrupt line agrees with the pending report.
- That the reported pin is a requesting pin with no lower-numbered one.

Only the bench scenarios can show the rest. This covers the address map, the polarity and edge qualifiers, the exact three-clock latency from pin to status, the one-clock width of pass-through edge pulses, and the preference for the low half. The bench drives pin patterns and compares the results against values it computes itself.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int AW = 6;

    typedef enum logic [2:0] {
        C_EN   = 3'd0,
        C_TYP  = 3'd1,
        C_LVL  = 3'd2,
        C_HOLD = 3'd3,
        C_FEN  = 3'd4,
        C_REN  = 3'd5
    } ctl_e;

    localparam int NCTL = 6;

    typedef struct packed {
        logic hit;
        logic stat;
        logic hi;
        ctl_e sel;
    } dec_t;

    typedef struct packed {
        logic edge_mode;
        logic act_high;
        logic fall_en;
        logic rise_en;
    } pin_cfg_t;

    // Map a byte offset to a register; bit 1 picks the high half.
    function automatic dec_t decode_addr(input logic [AW-1:0] a);
        dec_t d;
        d.hit  = 1'b1;
        d.stat = 1'b0;
        d.hi   = a[1];
        d.sel  = C_EN;
        case (a)
            6'h08, 6'h0A: d.stat = 1'b1;
            6'h0C, 6'h0E: d.sel  = C_EN;
            6'h10, 6'h12: d.sel  = C_TYP;
            6'h14, 6'h16: d.sel  = C_LVL;
            6'h18, 6'h1A: d.sel  = C_HOLD;
            6'h20, 6'h22: d.sel  = C_FEN;
            6'h24, 6'h26: d.sel  = C_REN;
            default:      d.hit  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gi_sync.sv
`timescale 1ns/1ps
module gi_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/gi_detect.sv
`timescale 1ns/1ps
module gi_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] fen,
    input  logic [W-1:0] ren,
    output logic [W-1:0] ev
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_s;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_cfg_t cfg;
        logic     rose, fell, edge_hit, lvl_hit;

        assign cfg      = '{edge_mode: typ[i], act_high: lvl[i],
                            fall_en: fen[i], rise_en: ren[i]};
        assign rose     = pin_s[i] & ~prev_q[i];
        assign fell     = ~pin_s[i] & prev_q[i];
        assign edge_hit = (cfg.rise_en & rose) | (cfg.fall_en & fell);
        assign lvl_hit  = cfg.act_high ? pin_s[i] : ~pin_s[i];
        assign ev[i]    = cfg.edge_mode ? edge_hit : lvl_hit;
    end
endmodule

// File: rtl/gi_regs.sv
`timescale 1ns/1ps
module gi_regs
    import gpio_irq_pkg::*;
#(
    parameter int DW = 16,
    localparam int PINS = 2 * DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [PINS-1:0] ev_vec,
    output logic [DW-1:0]   bus_rdata,
    output logic [PINS-1:0] en_q,
    output logic [PINS-1:0] typ_q,
    output logic [PINS-1:0] lvl_q,
    output logic [PINS-1:0] hold_q,
    output logic [PINS-1:0] fen_q,
    output logic [PINS-1:0] ren_q,
    output logic [PINS-1:0] stat_q,
    output logic [PINS-1:0] clr_vec
);
    logic [PINS-1:0] ctl_q [NCTL];
    dec_t            dec;
    logic            wr, rd;
    logic [PINS-1:0] rsrc;

    assign dec = decode_addr(bus_addr);
    assign wr  = bus_valid & bus_write & dec.hit;
    assign rd  = bus_valid & ~bus_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NCTL; k++) ctl_q[k] <= '0;
        end else if (wr && !dec.stat) begin
            if (dec.hi) ctl_q[dec.sel][PINS-1:DW] <= bus_wdata;
            else        ctl_q[dec.sel][DW-1:0]    <= bus_wdata;
        end
    end

    assign en_q   = ctl_q[C_EN];
    assign typ_q  = ctl_q[C_TYP];
    assign lvl_q  = ctl_q[C_LVL];
    assign hold_q = ctl_q[C_HOLD];
    assign fen_q  = ctl_q[C_FEN];
    assign ren_q  = ctl_q[C_REN];

    always_comb begin
        clr_vec = '0;
        if (wr && dec.stat) begin
            if (dec.hi) clr_vec[PINS-1:DW] = bus_wdata;
            else        clr_vec[DW-1:0]    = bus_wdata;
        end
    end

    // Held bits survive unless cleared; a fresh event always lands.
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (hold_q & stat_q & ~clr_vec) | ev_vec;
    end

    always_comb begin
        rsrc = '0;
        if (dec.stat)      rsrc = stat_q;
        else if (dec.hit)  rsrc = ctl_q[dec.sel];
    end

    always_ff @(posedge clk) begin
        if (rst)     bus_rdata <= '0;
        else if (rd) bus_rdata <= dec.hi ? rsrc[PINS-1:DW] : rsrc[DW-1:0];
    end
endmodule

// File: rtl/gi_prio.sv
`timescale 1ns/1ps
module gi_prio #(
    parameter int DW = 16,
    localparam int PINS = 2 * DW,
    localparam int IW = $clog2(DW),
    localparam int PW = $clog2(PINS)
) (
    input  logic [PINS-1:0] req,
    output logic            valid,
    output logic [PW-1:0]   pin
);
    function automatic logic [IW-1:0] first_one(input logic [DW-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = DW - 1; i >= 0; i--)
            if (v[i]) r = IW'(i);
        return r;
    endfunction

    logic [1:0]    any;
    logic [IW-1:0] idx [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign any[h] = |req[h*DW +: DW];
        assign idx[h] = first_one(req[h*DW +: DW]);
    end

    assign valid = |any;
    assign pin   = any[0] ? PW'(idx[0]) : PW'(idx[1]) + PW'(DW);
endmodule

// File: rtl/pin_event_irq.sv
`timescale 1ns/1ps
module pin_event_irq
    import gpio_irq_pkg::*;
#(
    parameter int DW = 16,
    localparam int PINS = 2 * DW,
    localparam int PW = $clog2(PINS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_i,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            pend_valid_o,
    output logic [PW-1:0]   pend_pin_o
);
    logic [PINS-1:0] pin_s, ev_vec, clr_vec;
    logic [PINS-1:0] en_q, typ_q, lvl_q, hold_q, fen_q, ren_q, stat_q;
    logic [PINS-1:0] req;

    gi_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(pin_s)
    );

    gi_detect #(.W(PINS)) u_det (
        .clk(clk), .rst(rst), .pin_s(pin_s), .typ(typ_q), .lvl(lvl_q),
        .fen(fen_q), .ren(ren_q), .ev(ev_vec)
    );

    gi_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ev_vec(ev_vec),
        .bus_rdata(bus_rdata), .en_q(en_q), .typ_q(typ_q), .lvl_q(lvl_q),
        .hold_q(hold_q), .fen_q(fen_q), .ren_q(ren_q), .stat_q(stat_q),
        .clr_vec(clr_vec)
    );

    assign req   = stat_q & en_q;
    assign irq_o = |req;

    gi_prio #(.DW(DW)) u_prio (
        .req(req), .valid(pend_valid_o), .pin(pend_pin_o)
    );
endmodule

// File: rtl/gi_checker.sv
`timescale 1ns/1ps
module gi_checker #(
    parameter int DW = 16,
    localparam int PINS = 2 * DW,
    localparam int PW = $clog2(PINS)
) (
    input logic            clk,
    input logic            rst,
    input logic [PINS-1:0] stat,
    input logic [PINS-1:0] en,
    input logic [PINS-1:0] hold,
    input logic [PINS-1:0] clr,
    input logic [PINS-1:0] ev,
    input logic            irq,
    input logic            pvalid,
    input logic [PW-1:0]   ppin
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (stat == '0 && en == '0));

    a_r10_irq_matches_report: assert property (@(posedge clk) disable iff (rst)
        irq == pvalid);

    a_r11_lowest_pin: assert property (@(posedge clk) disable iff (rst)
        pvalid |-> (stat[ppin] && en[ppin] &&
                    ((stat & en & ((PINS'(1) << ppin) - PINS'(1))) == '0)));

    a_r7_clear_removes: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(clr & ~ev)) == '0));

    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(ev)) == $past(ev)));

    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(hold & stat & ~clr)) == $past(hold & stat & ~clr)));
endmodule

bind pin_event_irq gi_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .stat(stat_q), .en(en_q), .hold(hold_q),
    .clr(clr_vec), .ev(ev_vec), .irq(irq_o), .pvalid(pend_valid_o),
    .ppin(pend_pin_o)
);

// File: tb/sim_pin_event_irq.sv
`timescale 1ns/1ps
module sim_pin_event_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, pend_valid_o;
    logic [4:0]  pend_pin_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_event_irq u0 (
        .clk(clk), .rst(rst), .pin_i(pins), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .pend_valid_o(pend_valid_o),
        .pend_pin_o(pend_pin_o)
    );

    logic [5:0] ctl_a [12] = '{6'h0C, 6'h0E, 6'h10, 6'h12, 6'h14, 6'h16,
                               6'h18, 6'h1A, 6'h20, 6'h22, 6'h24, 6'h26};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pins = '0;
        settle(2);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [31:0] p;

        // R1: reset state
        do_reset();
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 pend_valid", {31'd0, pend_valid_o}, 32'd0);
        for (int k = 0; k < 12; k++) begin
            rd(ctl_a[k], v);
            chk("R1 ctl zero", {16'd0, v}, 32'd0);
        end

        // R2: readback of every control register, unmapped reads zero
        for (int k = 0; k < 12; k++) wr(ctl_a[k], 16'hA5C3 ^ (16'h1111 * 16'(k)));
        for (int k = 0; k < 12; k++) begin
            rd(ctl_a[k], v);
            chk("R2 readback", {16'd0, v}, {16'd0, 16'hA5C3 ^ (16'h1111 * 16'(k))});
        end
        rd(6'h04, v); chk("R2 unmapped 04", {16'd0, v}, 32'd0);
        rd(6'h1C, v); chk("R2 unmapped 1C", {16'd0, v}, 32'd0);

        // R4 / R12: level mode, both polarities
        do_reset();
        settle(4);
        rd(6'h08, v); chk("R4 R12 active-low lo", {16'd0, v}, 32'h0000FFFF);
        rd(6'h0A, v); chk("R4 R12 active-low hi", {16'd0, v}, 32'h0000FFFF);
        wr(6'h14, 16'hFFFF); wr(6'h16, 16'hFFFF);
        settle(4);
        rd(6'h08, v); chk("R4 active-high idle lo", {16'd0, v}, 32'd0);
        rd(6'h0A, v); chk("R4 active-high idle hi", {16'd0, v}, 32'd0);
        pins = 32'h8001_0080;
        settle(4);
        rd(6'h08, v); chk("R4 pattern lo", {16'd0, v}, 32'h00000080);
        rd(6'h0A, v); chk("R4 pattern hi", {16'd0, v}, 32'h00008001);

        // R10 / R11: sweep every pin as the lowest requester
        wr(6'h0C, 16'hFFFF); wr(6'h0E, 16'hFFFF);
        for (int k = 0; k < 32; k++) begin
            pins = 32'h1 << k;
            settle(4);
            chk("R10 irq single", {31'd0, irq_o}, 32'd1);
            chk("R11 single pin", {27'd0, pend_pin_o}, k);
            p = ~((32'h1 << k) - 32'h1);
            pins = p | 32'h8000_0000;
            settle(4);
            chk("R11 pend_valid", {31'd0, pend_valid_o}, 32'd1);
            chk("R11 lowest of many", {27'd0, pend_pin_o}, k);
        end
        pins = 32'h0001_0008;
        settle(4);
        chk("R11 low half first", {27'd0, pend_pin_o}, 32'd3);
        pins = 32'h0202_0000;
        settle(4);
        chk("R11 high half offset", {27'd0, pend_pin_o}, 32'd17);
        pins = '0;
        settle(4);
        chk("R10 no request", {31'd0, irq_o}, 32'd0);
        chk("R11 no report", {31'd0, pend_valid_o}, 32'd0);
        pins = 32'hFFFF_FFFF;
        wr(6'h0C, 16'h0000);
        settle(1);
        chk("R11 high only", {27'd0, pend_pin_o}, 32'd16);
        wr(6'h0E, 16'h0000);
        settle(1);
        chk("R10 all disabled", {31'd0, irq_o}, 32'd0);

        // R5 / R6 / R7: held edge detection
        do_reset();
        wr(6'h10, 16'hFFFF); wr(6'h12, 16'hFFFF);
        wr(6'h18, 16'hFFFF); wr(6'h1A, 16'hFFFF);
        wr(6'h24, 16'h00FF); wr(6'h20, 16'hFF00);
        wr(6'h26, 16'hFFFF); wr(6'h22, 16'hFFFF);
        wr(6'h08, 16'hFFFF); wr(6'h0A, 16'hFFFF);
        rd(6'h08, v); chk("R7 cleared lo", {16'd0, v}, 32'd0);
        rd(6'h0A, v); chk("R7 cleared hi", {16'd0, v}, 32'd0);
        pins = 32'h0000_FFFF;
        settle(4);
        rd(6'h08, v); chk("R5 rising only", {16'd0, v}, 32'h000000FF);
        pins = 32'h0000_0000;
        settle(4);
        rd(6'h08, v); chk("R5 R6 falling plus held", {16'd0, v}, 32'h0000FFFF);
        pins = 32'hFFFF_0000;
        settle(4);
        rd(6'h0A, v); chk("R5 both edges hi", {16'd0, v}, 32'h0000FFFF);
        wr(6'h08, 16'h00F0);
        rd(6'h08, v); chk("R7 partial clear", {16'd0, v}, 32'h0000FF0F);
        settle(6);
        rd(6'h08, v); chk("R6 still held", {16'd0, v}, 32'h0000FF0F);

        // R8: event and clear in the same cycle
        wr(6'h08, 16'hFFFF);
        rd(6'h08, v); chk("R7 clear all", {16'd0, v}, 32'd0);
        @(negedge clk);
        pins = 32'hFFFF_0001;
        settle(1);
        wr(6'h08, 16'hFFFF);
        rd(6'h08, v); chk("R8 event beats clear", {16'd0, v}, 32'h00000001);
        wr(6'h08, 16'h0001);
        rd(6'h08, v); chk("R7 later clear", {16'd0, v}, 32'd0);

        // R3 / R9: pass-through edge pulse and its latency
        do_reset();
        wr(6'h10, 16'h0001); wr(6'h24, 16'h0001); wr(6'h0C, 16'h0001);
        settle(4);
        chk("R9 idle", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        pins = 32'h1;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            chk("R3 R9 pulse timing", {31'd0, irq_o}, (c == 3) ? 32'd1 : 32'd0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule